// File: doc/BRIEF.md
# Charge-Injection Self-Test Sequencer

This block runs the electrical self-test of a CCD line sensor. Instead of light, charge is injected into selected pixels. A single start pulse begins the run. The sequencer raises the sensor's test-mode pin and sends a fixed series of configuration writes to an external serial-bus master through a request/acknowledge handshake. It then writes the user's pixel stimulation pattern.

After that it enables the external analog test voltages and waits a settling interval. It fires one exposure pulse of fixed width and starts the readout controller. It waits for the sensor's data-ready flag, switches the test voltages off and writes the test registers back to their idle values. Finally it drops test mode and reports done, with a sticky failure flag.

Both time intervals come from a clock-frequency parameter: 10 µs of settling and a 20 µs exposure. The exposure width cannot be configured. A failed write during setup skips the exposure and goes straight to the restore writes, so the sensor never stays in test mode.

Top module: `sts_injseq`

## Requirements
- R1: After reset, and while idle, every output is low: write request, address, data, test mode, test-voltage enable, shutter, readout start, busy, done and fail.
- R2: Test mode is high from the cycle after start until the last restore write is acknowledged. Write requests occur only while test mode is high.
- R3: The setup writes go out in this order, as (address, data): (D0,4A), (D1,66), (D2,02), (D4,20), (D5,21). Each request keeps its address and data steady until the ack or error input is seen. Only one request is outstanding at a time.
- R4: The sixth write goes to address D3 with data {0, p[6:3], 001}, where p is the pattern input sampled in the start cycle. Bit 7 is always written as 0 and bits 2:0 are always written as 001.
- R5: The test-voltage enable rises only after the D3 write is acknowledged. It falls before the first restore write is requested, and no write request is raised while it is high.
- R6: With the test voltages on, exactly CLK_MHZ*10 clock cycles pass before the shutter rises.
- R7: Exactly one shutter pulse is issued per successful setup, and it is high for exactly CLK_MHZ*20 clock cycles.
- R8: After the shutter falls, readout start is pulsed for one cycle. With READY_WAIT=1, no restore write is requested until data-ready is seen high.
- R9: The restore writes go out in this order: (D4,00), (D5,01), (D2,00), (D3,00).
- R10: An error on any of the six setup writes cancels the remaining setup writes and the exposure. The run then goes straight to the four restore writes, and fail is set.
- R11: Done is a one-cycle pulse with test mode already low. Fail holds its value until the next accepted start clears it. A start while busy is ignored.
- R12: An error on a restore write sets fail, and the remaining restore writes are still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one self-test run (ignored when busy) |
| pattern_i | input | 8 | Pixel stimulation pattern, sampled at start |
| wr_req_o | output | 1 | Register write request to the bus master |
| wr_addr_o | output | 8 | Register address of the request |
| wr_data_o | output | 8 | Register data of the request |
| wr_ack_i | input | 1 | Write completed successfully |
| wr_err_i | input | 1 | Write failed (NACK or bus error) |
| test_mode_o | output | 1 | Sensor test-mode pin drive |
| ext_volt_en_o | output | 1 | Enable for external analog test voltages |
| shutter_o | output | 1 | Exposure pulse to the sensor |
| readout_go_o | output | 1 | One-cycle start for the readout controller |
| data_rdy_i | input | 1 | Sensor data-ready flag |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky failure status of the last run |

## Verification
A wrong write index shows up at the handshake port at once: on the next acknowledged request, the address/data pair no longer matches the ordered list. A timer fault shows within one exposure as a settling count or shutter width that differs from the CLK_MHZ multiples. A state machine that mishandles an error shows up before done: either the exposure still fires after a failed setup write, or restore writes go missing after a failed restore write. A stuck fail or busy state is visible a few cycles after done.

// File: rtl/sts_pkg.sv
package sts_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SETTLE,
      ST_EXPOSE,
      ST_RDGO,
      ST_RDWAIT,
      ST_TEAR,
      ST_FINISH
   } sts_state_e;

   typedef struct packed {
      logic [7:0] addr;
      logic [7:0] data;
   } sts_wr_t;

   localparam int          ITEM_W   = 4;
   localparam logic [3:0]  PAT_IDX  = 4'd5;
   localparam logic [3:0]  TEAR_IDX = 4'd6;
   localparam logic [3:0]  LAST_IDX = 4'd9;
   localparam int          SETTLE_US = 10;
   localparam int          EXPOSE_US = 20;

   function automatic logic [7:0] sts_clean_pat(input logic [7:0] raw);
      return {1'b0, raw[6:3], 3'b001};
   endfunction

   function automatic sts_wr_t sts_item(input logic [3:0] idx, input logic [7:0] pat);
      sts_wr_t w;
      case (idx)
         4'd0:    w = '{addr: 8'hD0, data: 8'h4A};
         4'd1:    w = '{addr: 8'hD1, data: 8'h66};
         4'd2:    w = '{addr: 8'hD2, data: 8'h02};
         4'd3:    w = '{addr: 8'hD4, data: 8'h20};
         4'd4:    w = '{addr: 8'hD5, data: 8'h21};
         4'd5:    w = '{addr: 8'hD3, data: sts_clean_pat(pat)};
         4'd6:    w = '{addr: 8'hD4, data: 8'h00};
         4'd7:    w = '{addr: 8'hD5, data: 8'h01};
         4'd8:    w = '{addr: 8'hD2, data: 8'h00};
         default: w = '{addr: 8'hD3, data: 8'h00};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/sts_wr_port.sv
module sts_wr_port
   import sts_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch_i,
   input  sts_wr_t    item_i,
   input  logic       ack_i,
   input  logic       err_i,
   output logic       req_o,
   output logic [7:0] addr_o,
   output logic [7:0] data_o,
   output logic       fin_o,
   output logic       fin_err_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_o  <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
      end else if (req_o && (ack_i || err_i)) begin
         req_o  <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
      end else if (launch_i && !req_o) begin
         req_o  <= 1'b1;
         addr_o <= item_i.addr;
         data_o <= item_i.data;
      end
   end

   assign fin_o     = req_o && (ack_i || err_i);
   assign fin_err_o = req_o && err_i;

endmodule

// File: rtl/sts_span_timer.sv
module sts_span_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [W-1:0] lim_i,
   output logic         last_o
);

   logic [W-1:0] cnt_q;

   assign last_o = run_i && (cnt_q == lim_i - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || last_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + W'(1);
   end

endmodule

// File: rtl/sts_ctrl.sv
module sts_ctrl
   import sts_pkg::*;
#(
   parameter int TW      = 8,
   parameter int SET_CYC = 10,
   parameter int EXP_CYC = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [7:0]    pattern_i,
   input  logic          fin_i,
   input  logic          fin_err_i,
   input  logic          wr_busy_i,
   input  logic          tm_last_i,
   input  logic          rdy_ok_i,
   output sts_state_e    state_o,
   output logic          launch_o,
   output sts_wr_t       item_o,
   output logic          tm_run_o,
   output logic [TW-1:0] tm_lim_o,
   output logic          fail_o
);

   sts_state_e st_q;
   logic [3:0] idx_q;
   logic [7:0] pat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         pat_q  <= '0;
         fail_o <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q   <= ST_SETUP;
               idx_q  <= '0;
               pat_q  <= pattern_i;
               fail_o <= 1'b0;
            end
            ST_SETUP: if (fin_i) begin
               if (fin_err_i) begin
                  st_q   <= ST_TEAR;
                  idx_q  <= TEAR_IDX;
                  fail_o <= 1'b1;
               end else if (idx_q == PAT_IDX) begin
                  st_q <= ST_SETTLE;
               end else begin
                  idx_q <= idx_q + 4'd1;
               end
            end
            ST_SETTLE: if (tm_last_i) st_q <= ST_EXPOSE;
            ST_EXPOSE: if (tm_last_i) st_q <= ST_RDGO;
            ST_RDGO:   st_q <= ST_RDWAIT;
            ST_RDWAIT: if (rdy_ok_i) begin
               st_q  <= ST_TEAR;
               idx_q <= TEAR_IDX;
            end
            ST_TEAR: if (fin_i) begin
               if (fin_err_i) fail_o <= 1'b1;
               if (idx_q == LAST_IDX) st_q <= ST_FINISH;
               else idx_q <= idx_q + 4'd1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o  = st_q;
   assign launch_o = ((st_q == ST_SETUP) || (st_q == ST_TEAR)) && !wr_busy_i;
   assign item_o   = sts_item(idx_q, pat_q);
   assign tm_run_o = (st_q == ST_SETTLE) || (st_q == ST_EXPOSE);
   assign tm_lim_o = (st_q == ST_EXPOSE) ? TW'(EXP_CYC) : TW'(SET_CYC);

endmodule

// File: rtl/sts_injseq.sv
module sts_injseq
   import sts_pkg::*;
#(
   parameter int CLK_MHZ    = 50,
   parameter bit READY_WAIT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] pattern_i,
   output logic       wr_req_o,
   output logic [7:0] wr_addr_o,
   output logic [7:0] wr_data_o,
   input  logic       wr_ack_i,
   input  logic       wr_err_i,
   output logic       test_mode_o,
   output logic       ext_volt_en_o,
   output logic       shutter_o,
   output logic       readout_go_o,
   input  logic       data_rdy_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       fail_o
);

   localparam int SET_CYC = CLK_MHZ * SETTLE_US;
   localparam int EXP_CYC = CLK_MHZ * EXPOSE_US;
   localparam int TW      = $clog2(EXP_CYC + 1);

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("sts_injseq: CLK_MHZ must be at least 1");
   end

   sts_state_e    state;
   sts_wr_t       item;
   logic          launch, fin, fin_err;
   logic          tm_run, tm_last, rdy_ok;
   logic [TW-1:0] tm_lim;

   if (READY_WAIT) begin : g_rdy_wait
      assign rdy_ok = data_rdy_i;
   end else begin : g_rdy_skip
      assign rdy_ok = 1'b1;
   end

   sts_ctrl #(.TW(TW), .SET_CYC(SET_CYC), .EXP_CYC(EXP_CYC)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .pattern_i (pattern_i),
      .fin_i     (fin),
      .fin_err_i (fin_err),
      .wr_busy_i (wr_req_o),
      .tm_last_i (tm_last),
      .rdy_ok_i  (rdy_ok),
      .state_o   (state),
      .launch_o  (launch),
      .item_o    (item),
      .tm_run_o  (tm_run),
      .tm_lim_o  (tm_lim),
      .fail_o    (fail_o)
   );

   sts_wr_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_i  (launch),
      .item_i    (item),
      .ack_i     (wr_ack_i),
      .err_i     (wr_err_i),
      .req_o     (wr_req_o),
      .addr_o    (wr_addr_o),
      .data_o    (wr_data_o),
      .fin_o     (fin),
      .fin_err_o (fin_err)
   );

   sts_span_timer #(.W(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (tm_run),
      .lim_i  (tm_lim),
      .last_o (tm_last)
   );

   assign test_mode_o   = (state != ST_IDLE) && (state != ST_FINISH);
   assign ext_volt_en_o = (state == ST_SETTLE) || (state == ST_EXPOSE) ||
                          (state == ST_RDGO)   || (state == ST_RDWAIT);
   assign shutter_o     = (state == ST_EXPOSE);
   assign readout_go_o  = (state == ST_RDGO);
   assign busy_o        = (state != ST_IDLE);
   assign done_o        = (state == ST_FINISH);

endmodule

// File: rtl/sts_injseq_chk.sv
module sts_injseq_chk #(
   parameter int CLK_MHZ = 50
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_req_o,
   input logic [7:0] wr_addr_o,
   input logic [7:0] wr_data_o,
   input logic       wr_ack_i,
   input logic       wr_err_i,
   input logic       test_mode_o,
   input logic       ext_volt_en_o,
   input logic       shutter_o,
   input logic       readout_go_o,
   input logic       done_o
);

   localparam int EXP_CYC = CLK_MHZ * 20;

   int sh_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sh_cnt <= 0;
      else if (shutter_o) sh_cnt <= sh_cnt + 1;
      else                sh_cnt <= 0;
   end

   a_r2_req_in_test_mode: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> test_mode_o);

   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_ack_i && !wr_err_i) |=>
         (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

   a_r4_pattern_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && wr_addr_o == 8'hD3 && wr_data_o != 8'h00) |->
         (wr_data_o[2:0] == 3'b001 && !wr_data_o[7]));

   a_r5_no_write_with_volts: assert property (@(posedge clk) disable iff (!rst_n)
      ext_volt_en_o |-> !wr_req_o);

   a_r6_volts_before_shutter: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutter_o) |-> $past(ext_volt_en_o));

   a_r7_shutter_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shutter_o) |-> (sh_cnt == EXP_CYC));

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({shutter_o, readout_go_o, wr_req_o}));

   a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!test_mode_o && !wr_req_o && !ext_volt_en_o));

endmodule

bind sts_injseq sts_injseq_chk #(.CLK_MHZ(CLK_MHZ)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_req_o      (wr_req_o),
   .wr_addr_o     (wr_addr_o),
   .wr_data_o     (wr_data_o),
   .wr_ack_i      (wr_ack_i),
   .wr_err_i      (wr_err_i),
   .test_mode_o   (test_mode_o),
   .ext_volt_en_o (ext_volt_en_o),
   .shutter_o     (shutter_o),
   .readout_go_o  (readout_go_o),
   .done_o        (done_o)
);

// File: tb/sim_sts_injseq.sv
module sim_sts_injseq;

   localparam int CLK_PERIOD = 10;
   localparam int MHZ        = 2;
   localparam int SET_CYC    = MHZ * 10;
   localparam int EXP_CYC    = MHZ * 20;
   localparam int RDY_DELAY  = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] pattern_i = 8'h00;
   logic       wr_req_o;
   logic [7:0] wr_addr_o, wr_data_o;
   logic       wr_ack_i = 1'b0, wr_err_i = 1'b0;
   logic       test_mode_o, ext_volt_en_o, shutter_o, readout_go_o;
   logic       data_rdy_i = 1'b0;
   logic       busy_o, done_o, fail_o;

   int total = 0, bad = 0;

   // bench-side stimulus knobs and observations
   int         ack_delay = 0, err_at = -1, dly_cnt = 0;
   int         log_n = 0;
   logic [7:0] log_a [16];
   logic [7:0] log_d [16];
   int         sh_high = 0, sh_pulses = 0, settle_n = 0, rdgo_n = 0, done_n = 0;
   int         overlap_n = 0, notm_n = 0, waitreq_n = 0, log_at_rdgo = -1;
   logic       sh_prev = 1'b0, waiting = 1'b0;

   sts_injseq #(.CLK_MHZ(MHZ), .READY_WAIT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pattern_i(pattern_i),
      .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .wr_ack_i(wr_ack_i), .wr_err_i(wr_err_i), .test_mode_o(test_mode_o),
      .ext_volt_en_o(ext_volt_en_o), .shutter_o(shutter_o),
      .readout_go_o(readout_go_o), .data_rdy_i(data_rdy_i), .busy_o(busy_o),
      .done_o(done_o), .fail_o(fail_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_addr(input int i);
      case (i)
         0: return 'hD0; 1: return 'hD1; 2: return 'hD2; 3: return 'hD4;
         4: return 'hD5; 5: return 'hD3; 6: return 'hD4; 7: return 'hD5;
         8: return 'hD2; default: return 'hD3;
      endcase
   endfunction

   function automatic int exp_data(input int i, input int p);
      case (i)
         0: return 'h4A; 1: return 'h66; 2: return 'h02; 3: return 'h20;
         4: return 'h21; 5: return (((p >> 3) & 15) << 3) + 1;
         6: return 'h00; 7: return 'h01; 8: return 'h00; default: return 'h00;
      endcase
   endfunction

   // write-handshake responder
   initial forever begin
      @(negedge clk);
      if (wr_ack_i || wr_err_i) begin
         wr_ack_i = 1'b0;
         wr_err_i = 1'b0;
      end else if (wr_req_o) begin
         if (dly_cnt >= ack_delay) begin
            if (log_n < 16) begin
               log_a[log_n] = wr_addr_o;
               log_d[log_n] = wr_data_o;
            end
            if (log_n == err_at) wr_err_i = 1'b1;
            else wr_ack_i = 1'b1;
            log_n++;
            dly_cnt = 0;
         end else begin
            dly_cnt++;
         end
      end
   end

   // readout controller model
   initial forever begin
      @(negedge clk);
      if (readout_go_o) begin
         repeat (RDY_DELAY) @(negedge clk);
         data_rdy_i = 1'b1;
         @(negedge clk);
         data_rdy_i = 1'b0;
      end
   end

   // port monitor
   initial forever begin
      @(negedge clk);
      if (shutter_o) sh_high++;
      if (shutter_o && !sh_prev) sh_pulses++;
      sh_prev = shutter_o;
      if (ext_volt_en_o && !shutter_o && sh_pulses == 0) settle_n++;
      if (wr_req_o && ext_volt_en_o) overlap_n++;
      if (wr_req_o && !test_mode_o) notm_n++;
      if (readout_go_o) begin
         rdgo_n++;
         waiting = 1'b1;
         log_at_rdgo = log_n;
      end
      if (data_rdy_i) waiting = 1'b0;
      if (waiting && wr_req_o) waitreq_n++;
      if (done_o) done_n++;
   end

   task automatic run_one(input int p, input int e, input int dly, input bit poke);
      int  n_exp;
      int  idx_exp [16];
      bit  got_done;
      bit  prev_fail;
      bit  full;
      @(negedge clk);
      prev_fail = fail_o;
      ack_delay = dly; err_at = e; dly_cnt = 0; log_n = 0;
      sh_high = 0; sh_pulses = 0; settle_n = 0; rdgo_n = 0; done_n = 0;
      overlap_n = 0; notm_n = 0; waitreq_n = 0; log_at_rdgo = -1;
      pattern_i = p[7:0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      pattern_i = ~p[7:0];   // R4: pattern must be the value seen at start
      if (prev_fail) chk(fail_o == 1'b0, "R11 fail cleared by start", fail_o, 0);
      chk(test_mode_o == 1'b1, "R2 test mode after start", test_mode_o, 1);
      got_done = 1'b0;
      for (int k = 0; k < 4000; k++) begin
         if (poke && k == 30) start_i = 1'b1;
         if (poke && k == 31) start_i = 1'b0;
         if (done_o) begin
            got_done = 1'b1;
            break;
         end
         @(negedge clk);
      end
      chk(got_done, "R11 done reached", got_done, 1);
      chk(test_mode_o == 1'b0, "R11 test mode low at done", test_mode_o, 0);
      repeat (3) @(negedge clk);
      full = (e < 0) || (e > 5);
      n_exp = 0;
      if (full) begin
         for (int i = 0; i < 10; i++) begin idx_exp[n_exp] = i; n_exp++; end
      end else begin
         for (int i = 0; i <= e; i++) begin idx_exp[n_exp] = i; n_exp++; end
         for (int i = 6; i < 10; i++) begin idx_exp[n_exp] = i; n_exp++; end
      end
      chk(log_n == n_exp, full ? "R9 write count" : "R10 write count", log_n, n_exp);
      for (int i = 0; i < n_exp && i < log_n; i++) begin
         chk(log_a[i] == 8'(exp_addr(idx_exp[i])),
             idx_exp[i] < 5 ? "R3 addr" : (idx_exp[i] == 5 ? "R4 addr" : "R9 addr"),
             log_a[i], exp_addr(idx_exp[i]));
         chk(log_d[i] == 8'(exp_data(idx_exp[i], p)),
             idx_exp[i] < 5 ? "R3 data" : (idx_exp[i] == 5 ? "R4 data" : "R9 data"),
             log_d[i], exp_data(idx_exp[i], p));
      end
      chk(sh_pulses == (full ? 1 : 0), full ? "R7 one shutter" : "R10 no shutter",
          sh_pulses, full ? 1 : 0);
      if (full) begin
         chk(sh_high == EXP_CYC, "R7 shutter width", sh_high, EXP_CYC);
         chk(settle_n == SET_CYC, "R6 settle cycles", settle_n, SET_CYC);
         chk(rdgo_n == 1, "R8 readout pulse", rdgo_n, 1);
         chk(log_at_rdgo == 6, "R5 volts after pattern write", log_at_rdgo, 6);
         chk(waitreq_n == 0, "R8 no write before data ready", waitreq_n, 0);
      end
      chk(overlap_n == 0, "R5 no write with volts", overlap_n, 0);
      chk(notm_n == 0, "R2 writes inside test mode", notm_n, 0);
      chk(done_n == 1, poke ? "R11 start while busy ignored" : "R11 one done pulse",
          done_n, 1);
      chk(busy_o == 1'b0, "R11 idle after done", busy_o, 0);
      chk(fail_o == (e >= 0), e > 5 ? "R12 fail on restore error" :
          (e >= 0 ? "R10 fail on setup error" : "R11 no fail"), fail_o, e >= 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({wr_req_o, test_mode_o, ext_volt_en_o, shutter_o, readout_go_o,
           busy_o, done_o, fail_o} == 8'h00, "R1 reset outputs", busy_o, 0);
      chk(wr_addr_o == 8'h00 && wr_data_o == 8'h00, "R1 reset bus", wr_addr_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy_o == 1'b0 && test_mode_o == 1'b0, "R1 idle after reset", busy_o, 0);
      for (int p = 0; p < 256; p++) run_one(p, -1, p % 3, 1'b0);
      for (int e = 0; e < 10; e++) run_one(8'h5B + e, e, e % 2, 1'b0);
      run_one(8'hFF, -1, 1, 1'b1);
      run_one(8'h00, -1, 0, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule